// File: doc/BRIEF.md
# Fast PWM Timer with Compare Output

This block is an 8-bit single-slope timer that produces one pulse-width-modulated waveform. A prescaler divides the input clock by a selectable factor and produces timer ticks. On each tick the counter steps up by one, and after 255 it returns to 0. One PWM period therefore lasts 256 ticks, and the output frequency is the clock divided by 256 times the prescale factor. The waveform pin changes level when the counter equals the active compare value and when the counter wraps. The output mode decides the polarity, or selects toggling or an idle low pin.

Software writes the compare value into a buffer. The timer copies the buffer into the active compare register only when the counter wraps, so a new duty cycle always begins at a period boundary and never produces a glitch. Two sticky flags report the wrap and the compare match. Each flag is cleared by writing a one to its bit.

Top module: `fpwm_timer`

## Requirements
- R1: After reset, pwm_out, ovf_flag and cmp_flag are 0, the output mode is off and the clock select is 0 (stopped). An asynchronous reset applied during operation forces the same state.
- R2: While the clock select field is 0, the counter holds its value. No flag is set and pwm_out keeps its level.
- R3: Clock select values 1 to 7 choose the prescale factors 1, 8, 32, 64, 128, 256 and 1024. The overflow flag then rises once every 256 times the factor clock cycles. Writing a different clock select value restarts the prescaler from zero.
- R4: The counter counts from 0 to 255 and wraps to 0 on the next tick. ovf_flag is set at that same wrap edge, so it becomes visible with the counter at 0.
- R5: A write to address 0 (compare value, bits 7:0) goes into a buffer. The buffer reaches the active compare register only at the wrap, so the period in progress keeps the old value.
- R6: Output mode 2 (control bits 5:4 = 2) gives a non-inverted PWM. The pin is set at the wrap and cleared at the compare match, so it is high for C+1 ticks out of 256.
- R7: Output mode 3 gives the inverted PWM. The pin is cleared at the wrap and set at the match, so it is high for 255-C ticks out of 256.
- R8: Output mode 1 toggles the pin at every compare match. This gives a 50% duty square wave with a period of 512 ticks.
- R9: Output mode 0 drives pwm_out low.
- R10: A compare value of 0 gives a one-tick spike in every period. A compare value of 255 gives a constant level (high in mode 2, low in mode 3), because the wrap takes priority over the match.
- R11: cmp_flag is set at the tick edge where the counter equals the active compare value. This is the same edge at which the PWM pin changes at the match.
- R12: A write to address 2 clears the overflow flag when bit 0 is 1 and the compare flag when bit 1 is 1. A set event in the same cycle as the clear wins, and the flag stays 1.

Control register is address 1: clock select in bits 2:0 and output mode in bits 5:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 compare buffer, 1 control, 2 flag clear |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 1 | Waveform output |
| ovf_flag | output | 1 | Sticky wrap flag |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
The counter is not visible at the ports, so the hardest cases to reach are the ones that need the exact tick of a match. These are a flag clear that lands on the same edge as the match, and a compare write made in the middle of a period. The bench uses the overflow flag as a time reference: the first clock low phase in which the flag is seen is exactly one cycle after the wrap. At the divide-by-one setting, each later cycle then maps to a known counter value. From that point the bench counts cycles to place the clear on the match edge, and it measures the high run of the period in progress and of the period after it.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

   typedef enum logic [1:0] {
      OM_OFF     = 2'd0,
      OM_TOGGLE  = 2'd1,
      OM_PWM     = 2'd2,
      OM_PWM_INV = 2'd3
   } out_mode_e;

   localparam logic [1:0] ADDR_CMP  = 2'd0;
   localparam logic [1:0] ADDR_CTRL = 2'd1;
   localparam logic [1:0] ADDR_FCLR = 2'd2;

   localparam int CS_W      = 3;
   localparam int CS_LSB    = 0;
   localparam int MODE_LSB  = 4;
   localparam int FLAG_OVF  = 0;
   localparam int FLAG_CMP  = 1;
   localparam int NUM_FLAGS = 2;
   localparam int MAX_SHIFT = 10;

   // log2 of the prescale factor for each clock select code
   function automatic int unsigned div_shift(input logic [CS_W-1:0] cs);
      case (cs)
         3'd1:    div_shift = 0;
         3'd2:    div_shift = 3;
         3'd3:    div_shift = 5;
         3'd4:    div_shift = 6;
         3'd5:    div_shift = 7;
         3'd6:    div_shift = 8;
         3'd7:    div_shift = 10;
         default: div_shift = 0;
      endcase
   endfunction

endpackage

// File: rtl/fpwm_prescale.sv
module fpwm_prescale
   import fpwm_pkg::*;
#(
   parameter int PS_W = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CS_W-1:0] cs,
   input  logic            restart,
   output logic            tick
);

   logic [PS_W-1:0] div_q;
   logic [PS_W-1:0] div_mask;

   always_comb begin
      div_mask = (PS_W'(1) << div_shift(cs)) - PS_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (restart || (cs == '0)) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + PS_W'(1);
      end
   end

   assign tick = (cs != '0) && ((div_q & div_mask) == div_mask);

   AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(restart) && (cs > 3'd1)) |-> !tick); // R3

endmodule

// File: rtl/fpwm_counter.sv
module fpwm_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] cmp_buf,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap,
   output logic             match
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] act_q;

   assign wrap  = tick && (cnt_q == CNT_MAX);
   assign match = tick && (cnt_q == act_q);
   assign cnt   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= '0;
      end else if (tick) begin
         if (wrap) begin
            cnt_q <= '0;
            act_q <= cmp_buf;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt_q == '0)); // R4
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wrap) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4
   AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(act_q)); // R5

endmodule

// File: rtl/fpwm_wave.sv
module fpwm_wave
   import fpwm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  out_mode_e mode,
   input  logic      wrap,
   input  logic      match,
   output logic      pin
);

   logic pin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= 1'b0;
      end else begin
         case (mode)
            OM_TOGGLE: if (match) pin_q <= ~pin_q;
            OM_PWM: begin
               if (wrap)       pin_q <= 1'b1;
               else if (match) pin_q <= 1'b0;
            end
            OM_PWM_INV: begin
               if (wrap)       pin_q <= 1'b0;
               else if (match) pin_q <= 1'b1;
            end
            default: pin_q <= 1'b0;
         endcase
      end
   end

   assign pin = pin_q;

   AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == OM_OFF) |=> !pin_q); // R9
   AST_PWM_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == OM_PWM) && wrap) |=> pin_q); // R6
   AST_INV_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == OM_PWM_INV) && wrap) |=> !pin_q); // R7
   AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == OM_TOGGLE) && match) |=> (pin_q != $past(pin_q))); // R8

endmodule

// File: rtl/fpwm_flags.sv
module fpwm_flags #(
   parameter int NF = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set,
   input  logic [NF-1:0] clr,
   output logic [NF-1:0] flag
);

   for (genvar i = 0; i < NF; i++) begin : g_flag
      logic flag_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q <= 1'b0;
         end else if (set[i]) begin
            flag_q <= 1'b1;
         end else if (clr[i]) begin
            flag_q <= 1'b0;
         end
      end

      assign flag[i] = flag_q;

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> flag_q); // R12
      AST_CLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !set[i]) |=> !flag_q); // R12
   end

endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer
   import fpwm_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int PS_W   = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              pwm_out,
   output logic              ovf_flag,
   output logic              cmp_flag
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("fpwm_timer: CNT_W must be at least 2");
   end
   if (PS_W < MAX_SHIFT) begin : g_bad_ps
      $error("fpwm_timer: PS_W too narrow for the largest prescale factor");
   end
   if ((DATA_W < CNT_W) || (DATA_W < MODE_LSB + 2)) begin : g_bad_data
      $error("fpwm_timer: DATA_W too narrow for the register fields");
   end

   logic [CNT_W-1:0]     cmp_buf_q;
   out_mode_e            mode_q;
   logic [CS_W-1:0]      cs_q;
   logic                 wr_cmp, wr_ctrl, wr_fclr;
   logic                 restart, tick, wrap, match;
   logic [CNT_W-1:0]     cnt;
   logic [NUM_FLAGS-1:0] flag_set, flag_clr, flags;

   assign wr_cmp  = wr_en && (wr_addr == ADDR_CMP);
   assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
   assign wr_fclr = wr_en && (wr_addr == ADDR_FCLR);
   assign restart = wr_ctrl && (wr_data[CS_LSB +: CS_W] != cs_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_buf_q <= '0;
         mode_q    <= OM_OFF;
         cs_q      <= '0;
      end else begin
         if (wr_cmp) begin
            cmp_buf_q <= wr_data[CNT_W-1:0];
         end
         if (wr_ctrl) begin
            mode_q <= out_mode_e'(wr_data[MODE_LSB +: 2]);
            cs_q   <= wr_data[CS_LSB +: CS_W];
         end
      end
   end

   fpwm_prescale #(.PS_W(PS_W)) u_prescale (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs      (cs_q),
      .restart (restart),
      .tick    (tick)
   );

   fpwm_counter #(.CNT_W(CNT_W)) u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .cmp_buf (cmp_buf_q),
      .cnt     (cnt),
      .wrap    (wrap),
      .match   (match)
   );

   fpwm_wave u_wave (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode_q),
      .wrap  (wrap),
      .match (match),
      .pin   (pwm_out)
   );

   always_comb begin
      flag_set           = '0;
      flag_set[FLAG_OVF] = wrap;
      flag_set[FLAG_CMP] = match;
      flag_clr           = wr_fclr ? wr_data[NUM_FLAGS-1:0] : '0;
   end

   fpwm_flags #(.NF(NUM_FLAGS)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set),
      .clr   (flag_clr),
      .flag  (flags)
   );

   assign ovf_flag = flags[FLAG_OVF];
   assign cmp_flag = flags[FLAG_CMP];

   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_q == '0) |=> $stable(cnt)); // R2
   AST_OVF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> (cnt == '0)); // R4

endmodule

// File: tb/tb_fpwm_timer.sv
module tb_fpwm_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic       pwm_out, ovf_flag, cmp_flag;

   int n_checks = 0;
   int n_fails  = 0;

   always #5 clk = ~clk;

   fpwm_timer dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .pwm_out  (pwm_out),
      .ovf_flag (ovf_flag),
      .cmp_flag (cmp_flag)
   );

   // {mode, compare value, expected high cycles in 512, requirement}
   localparam int NVEC = 9;
   localparam int VEC [0:NVEC-1][0:3] = '{
      '{2,   0,   2, 10},  // R10 spike
      '{2, 100, 202,  6},  // R6
      '{2, 255, 512, 10},  // R10 constant high
      '{2, 127, 256,  6},  // R6
      '{3,   0, 510,  7},  // R7
      '{3, 200, 110,  7},  // R7
      '{3, 255,   0, 10},  // R10 constant low
      '{1,  50, 256,  8},  // R8
      '{0,  77,   0,  9}   // R9
   };

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_ovf();
      wr(2'd2, 8'h01);
      while (!ovf_flag) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      int hi, run, cyc, p0, bad;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 pin", pwm_out, 0);
      chk("R1 flags", {ovf_flag, cmp_flag}, 0);
      rst_n = 1'b1;
      // R2 stopped after reset
      repeat (300) @(negedge clk);
      chk("R2 idle flags", {ovf_flag, cmp_flag}, 0);

      // table of modes and compare values, divide by one
      for (int v = 0; v < NVEC; v++) begin
         wr(2'd1, 8'((VEC[v][0] << 4) | 1));
         wr(2'd0, 8'(VEC[v][1]));
         wait_ovf();
         wait_ovf();
         hi = 0;
         for (int k = 0; k < 512; k++) begin
            @(negedge clk);
            if (pwm_out) hi++;
         end
         chk($sformatf("R%0d mode %0d cmp %0d", VEC[v][3], VEC[v][0], VEC[v][1]), hi, VEC[v][2]);
      end

      // R4 / R6: flag and rising pin on the same wrap edge
      wr(2'd1, 8'h21);
      wr(2'd0, 8'd10);
      wait_ovf();
      wait_ovf();
      wr(2'd2, 8'h01);
      chk("R12 ovf clear", ovf_flag, 0);
      p0 = pwm_out;
      while (!ovf_flag) begin
         p0 = pwm_out;
         @(negedge clk);
      end
      chk("R4 pin low before wrap", p0, 0);
      chk("R4 pin high with flag", pwm_out, 1);

      // R5: mid-period write keeps the old value this period
      run = pwm_out ? 1 : 0;
      wr(2'd0, 8'd200);
      while (pwm_out) begin
         run++;
         @(negedge clk);
      end
      chk("R5 old value in current period", run, 11);
      wait_ovf();
      run = 0;
      while (pwm_out) begin
         run++;
         @(negedge clk);
      end
      chk("R5 new value next period", run, 201);

      // R11 / R12: compare flag timing and set-over-clear
      wr(2'd0, 8'd10);
      wait_ovf();
      wait_ovf();
      wr(2'd2, 8'h02);              // now one cycle after wrap
      chk("R12 cmp clear", cmp_flag, 0);
      repeat (8) @(negedge clk);    // nine cycles after wrap
      chk("R11 no early flag", cmp_flag, 0);
      chk("R11 pin before match", pwm_out, 1);
      @(negedge clk);
      wr(2'd2, 8'h02);              // clear on the match edge
      chk("R12 set wins over clear", cmp_flag, 1);
      chk("R11 pin falls at match", pwm_out, 0);
      wr(2'd2, 8'h02);
      chk("R12 cmp clear after match", cmp_flag, 0);

      // R3: overflow period for several prescale factors
      for (int c = 1; c <= 3; c++) begin
         wr(2'd1, 8'(8'h20 | c));
         wait_ovf();
         wr(2'd2, 8'h01);
         cyc = 1;
         while (!ovf_flag) begin
            @(negedge clk);
            cyc++;
         end
         chk($sformatf("R3 period cs %0d", c), cyc, (c == 1) ? 256 : (c == 2) ? 2048 : 8192);
      end

      // R2: stop holds everything
      wr(2'd1, 8'h21);
      wr(2'd0, 8'd100);
      wait_ovf();
      wait_ovf();
      wr(2'd1, 8'h20);
      wr(2'd2, 8'h03);
      p0 = pwm_out;
      bad = 0;
      for (int k = 0; k < 600; k++) begin
         @(negedge clk);
         if (pwm_out != p0) bad++;
      end
      chk("R2 pin held while stopped", bad, 0);
      chk("R2 no flags while stopped", {ovf_flag, cmp_flag}, 0);

      // R1: reset during operation
      wr(2'd1, 8'h31);
      wr(2'd0, 8'd0);
      wait_ovf();
      wait_ovf();
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 pin in reset", pwm_out, 0);
      chk("R1 flags in reset", {ovf_flag, cmp_flag}, 0);
      rst_n = 1'b1;
      repeat (300) @(negedge clk);
      chk("R1 idle after reset", {pwm_out, ovf_flag, cmp_flag}, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule